// File: doc/BRIEF.md
# Front panel input status controller

This block gathers the operator inputs of a front panel, a rotary knob with two quadrature channels and a set of push buttons, into a small status interface for a host processor. The knob and button lines arrive already smoothed by external RC networks. Inside the block each line is brought into the clock domain through a flop chain. The two knob channels then pass through a Gray-code step decoder. A valid step raises a sticky knob interrupt flag and latches a direction bit for clockwise or counter-clockwise motion.

The button lines are combined into one level-sensitive button interrupt. The host reads it together with the knob flags, then reads a second register to see which buttons are held. The host clears the knob flag by writing to the knob status register, and it arms a watchdog enable by writing to the button register. Address decoding for both registers sits inside the block.

Top module: `fp_status_ctrl`

## Requirements
- R1: After reset every register read returns 0x00, and `knob_irq`, `btn_irq` and `wdt_en` are low.
- R2: A legal clockwise step (channel A leading B, AB sequence 00→10→11→01→00) sets the knob flag (bit 0 of offset 0xA) and the clockwise bit (bit 4 of offset 0xA). This happens three clock edges after the channel change.
- R3: A legal counter-clockwise step (AB sequence 00→01→11→10→00) sets the knob flag and the counter-clockwise bit (bit 5 of offset 0xA).
- R4: A jump in which both channels change in the same sample is ignored. The flag and direction bits keep their values.
- R5: The knob flag stays set while the knob is idle, until it is cleared by a write.
- R6: Any write to offset 0xA, whatever the data, clears the knob flag and both direction bits.
- R7: If a step is detected on the same edge as a clearing write, the flag and the new direction bit end up set.
- R8: `btn_irq`, which is also bit 1 of offset 0xA, is the OR of the synchronized button lines. It is not latched and falls once every button is released.
- R9: A read of offset 0xC returns the synchronized buttons in bits 7..3. Button 0 (knob push) is in bit 3 and buttons 1..4 are in bits 4..7.
- R10: Any write to offset 0xC sets `wdt_en`, which is also bit 0 of offset 0xC. It stays set until reset.
- R11: Reads of other offsets return 0x00. Writes to other offsets change no state.
- R12: A new step replaces the previous direction, so at most one direction bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| knob_a | input | 1 | Knob quadrature channel A |
| knob_b | input | 1 | Knob quadrature channel B |
| btn_in | input | NUM_BTN | Push-button lines, bit 0 is the knob push |
| bus_sel | input | 1 | Chip select for the register window |
| bus_wr | input | 1 | Write strobe (read when low) |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data (ignored by both registers) |
| bus_rdata | output | DATA_W | Read data, combinational, zero when not reading |
| knob_irq | output | 1 | Sticky knob-turned flag |
| btn_irq | output | 1 | OR of the synchronized buttons |
| wdt_en | output | 1 | Watchdog enable |

## Verification
A knob change becomes visible three rising edges after it is driven: two synchronizer flops, then the flag register. A button change reaches `btn_irq` and offset 0xC after two edges. A write acts on the edge that samples it. The bench drives on falling edges, waits the full latency before queuing an expectation, and the monitor reads the register half a period later. For the set-wins case, the clearing write is placed on exactly the third edge after the knob change.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;
   typedef enum logic [1:0] {
      TURN_NONE = 2'b00,
      TURN_CW   = 2'b01,
      TURN_CCW  = 2'b10
   } turn_t;
endpackage

// File: rtl/fp_sync.sv
module fp_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("fp_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fp_quad_dec.sv
module fp_quad_dec
   import fp_status_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ab,
   output turn_t      turn
);
   logic [1:0] prev_ab;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_ab <= 2'b00;
      else        prev_ab <= ab;
   end

   always_comb begin
      unique case ({prev_ab, ab})
         4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: turn = TURN_CW;
         4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: turn = TURN_CCW;
         default:                                turn = TURN_NONE;
      endcase
   end
endmodule

// File: rtl/fp_host_regs.sv
module fp_host_regs
   import fp_status_pkg::*;
#(
   parameter int              NUM_BTN  = 5,
   parameter int              ADDR_W   = 4,
   parameter int              DATA_W   = 8,
   parameter logic [ADDR_W-1:0] KNOB_OFS = 'hA,
   parameter logic [ADDR_W-1:0] BTN_OFS  = 'hC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  turn_t              turn,
   input  logic [NUM_BTN-1:0] btn_s,
   input  logic               btn_any,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               knob_flag,
   output logic               dir_cw,
   output logic               dir_ccw,
   output logic               wdt_q
);
   localparam int FLAG_BIT = 0;
   localparam int BIRQ_BIT = 1;
   localparam int CW_BIT   = 4;
   localparam int CCW_BIT  = 5;
   localparam int WDT_BIT  = 0;
   localparam int BTN_LSB  = DATA_W - NUM_BTN;

   generate
      if (DATA_W <= CCW_BIT) begin : g_bad_width
         $error("fp_host_regs: data bus too narrow for direction bits");
      end
      if (NUM_BTN + 1 > DATA_W) begin : g_bad_btn
         $error("fp_host_regs: too many buttons for data bus");
      end
   endgenerate

   logic clr_knob, set_wdt, rd_en;

   assign clr_knob = bus_sel && bus_wr && (bus_addr == KNOB_OFS);
   assign set_wdt  = bus_sel && bus_wr && (bus_addr == BTN_OFS);
   assign rd_en    = bus_sel && !bus_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         knob_flag <= 1'b0;
         dir_cw    <= 1'b0;
         dir_ccw   <= 1'b0;
      end else if (turn != TURN_NONE) begin
         knob_flag <= 1'b1;
         dir_cw    <= (turn == TURN_CW);
         dir_ccw   <= (turn == TURN_CCW);
      end else if (clr_knob) begin
         knob_flag <= 1'b0;
         dir_cw    <= 1'b0;
         dir_ccw   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wdt_q <= 1'b0;
      else if (set_wdt) wdt_q <= 1'b1;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_en) begin
         if (bus_addr == KNOB_OFS) begin
            bus_rdata[FLAG_BIT] = knob_flag;
            bus_rdata[BIRQ_BIT] = btn_any;
            bus_rdata[CW_BIT]   = dir_cw;
            bus_rdata[CCW_BIT]  = dir_ccw;
         end else if (bus_addr == BTN_OFS) begin
            bus_rdata[BTN_LSB +: NUM_BTN] = btn_s;
            bus_rdata[WDT_BIT]            = wdt_q;
         end
      end
   end
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
   import fp_status_pkg::*;
#(
   parameter int                NUM_BTN     = 5,
   parameter int                SYNC_STAGES = 2,
   parameter int                ADDR_W      = 4,
   parameter int                DATA_W      = 8,
   parameter logic [ADDR_W-1:0] KNOB_OFS    = 'hA,
   parameter logic [ADDR_W-1:0] BTN_OFS     = 'hC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               knob_a,
   input  logic               knob_b,
   input  logic [NUM_BTN-1:0] btn_in,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               knob_irq,
   output logic               btn_irq,
   output logic               wdt_en
);
   localparam int IN_W = NUM_BTN + 2;

   generate
      if (KNOB_OFS == BTN_OFS) begin : g_bad_map
         $error("fp_status_ctrl: register offsets collide");
      end
   endgenerate

   logic [IN_W-1:0]    raw_in, sync_out;
   logic [1:0]         ab_s;
   logic [NUM_BTN-1:0] btn_s;
   turn_t              turn_s;
   logic               dir_cw, dir_ccw;
   logic               wdata_unused;

   assign raw_in       = {btn_in, knob_b, knob_a};
   assign ab_s         = {sync_out[0], sync_out[1]};
   assign btn_s        = sync_out[IN_W-1:2];
   assign btn_irq      = |btn_s;
   assign wdata_unused = ^bus_wdata;

   fp_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
   );

   fp_quad_dec u_dec (
      .clk(clk), .rst_n(rst_n), .ab(ab_s), .turn(turn_s)
   );

   fp_host_regs #(
      .NUM_BTN(NUM_BTN), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .KNOB_OFS(KNOB_OFS), .BTN_OFS(BTN_OFS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .turn(turn_s), .btn_s(btn_s),
      .btn_any(btn_irq), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_rdata(bus_rdata),
      .knob_flag(knob_irq), .dir_cw(dir_cw), .dir_ccw(dir_ccw),
      .wdt_q(wdt_en)
   );
endmodule

// File: rtl/fp_status_ctrl_chk.sv
module fp_status_ctrl_chk
   import fp_status_pkg::*;
#(
   parameter int                ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] KNOB_OFS = 'hA
) (
   input logic              clk,
   input logic              rst_n,
   input turn_t             turn,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              knob_irq,
   input logic              dir_cw,
   input logic              dir_ccw,
   input logic              wdt_en
);
   logic clr;
   assign clr = bus_sel && bus_wr && (bus_addr == KNOB_OFS);

   // R2 R3 R7
   step_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (turn != TURN_NONE) |=> knob_irq);

   // R12
   cw_replaces_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (turn == TURN_CW) |=> (dir_cw && !dir_ccw));

   // R12
   ccw_replaces_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (turn == TURN_CCW) |=> (dir_ccw && !dir_cw));

   // R5
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (knob_irq && !clr) |=> knob_irq);

   // R6
   flag_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(knob_irq) |-> $past(clr));

   // R10
   wdt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_en |=> wdt_en);
endmodule

bind fp_status_ctrl fp_status_ctrl_chk #(.ADDR_W(ADDR_W), .KNOB_OFS(KNOB_OFS)) u_chk (
   .clk(clk), .rst_n(rst_n), .turn(turn_s), .bus_sel(bus_sel),
   .bus_wr(bus_wr), .bus_addr(bus_addr), .knob_irq(knob_irq),
   .dir_cw(dir_cw), .dir_ccw(dir_ccw), .wdt_en(wdt_en)
);

// File: tb/tb_fp_status_ctrl.sv
module tb_fp_status_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       knob_a = 1'b0, knob_b = 1'b0;
   logic [4:0] btn_in = '0;
   logic       bus_sel, bus_wr;
   logic [3:0] bus_addr;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       knob_irq, btn_irq, wdt_en;

   logic       wr_sel = 1'b0, rd_sel = 1'b0;
   logic [3:0] wr_addr = '0, rd_addr = '0;

   assign bus_sel  = wr_sel | rd_sel;
   assign bus_wr   = wr_sel;
   assign bus_addr = wr_sel ? wr_addr : rd_addr;

   always #2.5 clk = ~clk;

   fp_status_ctrl dut (
      .clk(clk), .rst_n(rst_n), .knob_a(knob_a), .knob_b(knob_b),
      .btn_in(btn_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .knob_irq(knob_irq), .btn_irq(btn_irq), .wdt_en(wdt_en)
   );

   typedef struct {
      logic [3:0] addr;
      logic [7:0] rdata;
      logic       kirq;
      logic       birq;
      logic       wdt;
      string      tag;
   } item_t;

   item_t q[$];
   int    pending = 0;
   int    checks = 0, errors = 0;

   logic       m_flag = 0, m_cw = 0, m_ccw = 0, m_wdt = 0;
   logic [4:0] m_btn = '0;

   function automatic logic [7:0] model_rd(logic [3:0] a);
      logic [7:0] v = '0;
      if (a == 4'hA) begin
         v[0] = m_flag; v[1] = |m_btn; v[4] = m_cw; v[5] = m_ccw;
      end else if (a == 4'hC) begin
         v[7:3] = m_btn; v[0] = m_wdt;
      end
      return v;
   endfunction

   task automatic expect_rd(logic [3:0] a, string tag);
      item_t it;
      it.addr = a; it.rdata = model_rd(a); it.kirq = m_flag;
      it.birq = |m_btn; it.wdt = m_wdt; it.tag = tag;
      pending++;
      q.push_back(it);
      wait (pending == 0);
   endtask

   task automatic cmp(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // monitor: pops items and compares at the bus
   initial begin
      forever begin
         item_t it;
         wait (q.size() > 0);
         it = q.pop_front();
         @(negedge clk);
         rd_addr = it.addr; rd_sel = 1'b1;
         #1;
         cmp(it.tag, "rdata", bus_rdata, it.rdata);
         cmp(it.tag, "knob_irq", knob_irq, it.kirq);
         cmp(it.tag, "btn_irq", btn_irq, it.birq);
         cmp(it.tag, "wdt_en", wdt_en, it.wdt);
         rd_sel = 1'b0;
         pending--;
      end
   end

   task automatic bus_write(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      wr_addr = a; bus_wdata = d; wr_sel = 1'b1;
      @(negedge clk);
      wr_sel = 1'b0;
   endtask

   task automatic knob_to(logic a, logic b);
      @(negedge clk);
      knob_a = a; knob_b = b;
      repeat (3) @(posedge clk);
   endtask

   task automatic btn_to(logic [4:0] v);
      @(negedge clk);
      btn_in = v; m_btn = v;
      repeat (3) @(posedge clk);
   endtask

   task automatic set_cw();  m_flag = 1; m_cw = 1; m_ccw = 0; endtask
   task automatic set_ccw(); m_flag = 1; m_cw = 0; m_ccw = 1; endtask
   task automatic clr_m();   m_flag = 0; m_cw = 0; m_ccw = 0; endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      expect_rd(4'hA, "R1");
      expect_rd(4'hC, "R1");
      expect_rd(4'h0, "R11");

      knob_to(1, 0); set_cw();            // 00 -> 10
      expect_rd(4'hA, "R2");
      repeat (10) @(posedge clk);
      expect_rd(4'hA, "R5");

      bus_write(4'hA, 8'h00); clr_m();
      expect_rd(4'hA, "R6");

      knob_to(1, 1); set_cw();            // 10 -> 11
      bus_write(4'h8, 8'hFF);             // other offset: no effect
      expect_rd(4'hA, "R11");
      bus_write(4'hA, 8'hFF); clr_m();
      expect_rd(4'hA, "R6");

      knob_to(1, 0); set_ccw();           // 11 -> 10
      expect_rd(4'hA, "R3");
      knob_to(1, 1); set_cw();            // 10 -> 11
      expect_rd(4'hA, "R12");
      knob_to(1, 0); set_ccw();           // 11 -> 10
      expect_rd(4'hA, "R12");
      bus_write(4'hA, 8'h5A); clr_m();

      knob_to(0, 1);                      // 10 -> 01 illegal
      expect_rd(4'hA, "R4");
      knob_to(1, 1); set_ccw();           // 01 -> 11 ccw
      knob_to(0, 0);                      // 11 -> 00 illegal
      expect_rd(4'hA, "R4");

      // same-edge set and clear: AB 00 -> 10 (cw)
      @(negedge clk);
      knob_a = 1; knob_b = 0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      wr_addr = 4'hA; wr_sel = 1'b1;
      @(negedge clk);
      wr_sel = 1'b0;
      set_cw();
      expect_rd(4'hA, "R7");
      bus_write(4'hA, 8'h00); clr_m();

      btn_to(5'b00001);
      expect_rd(4'hA, "R8");
      expect_rd(4'hC, "R9");
      btn_to(5'b10010);
      expect_rd(4'hC, "R9");
      expect_rd(4'hA, "R8");
      btn_to(5'b00000);
      expect_rd(4'hA, "R8");

      bus_write(4'hC, 8'h00); m_wdt = 1;
      expect_rd(4'hC, "R10");
      bus_write(4'hA, 8'h00);
      repeat (5) @(posedge clk);
      expect_rd(4'hC, "R10");
      expect_rd(4'h6, "R11");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule